// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry-Out

This block is purely combinational. It turns a 32-bit source value into the second operand of a data-processing ALU. It also produces the shifter carry bit that the flag logic uses for logical operations. A 2-bit kind code selects one of four shift kinds, and a 5-bit amount from 0 to 31 gives the distance. A separate extended-rotate select overrides both of them. It rotates the 33-bit quantity formed by the incoming carry flag above bit 31 and the source value by one place.

Each of the four kinds is built as its own logarithmic stage chain, with one stage per amount bit. A final selector picks the chain for the kind code, or the extended-rotate value. A separate carry picker indexes the source value to find the last bit shifted out. When no bit leaves the word, the picker passes the incoming carry through.

The block has no clock, reset or state. Its outputs settle within one combinational path from any input change, so a pipeline stage can place it between its operand registers.

Top module: `opshift_unit`

## Requirements
- R1: With the extended-rotate select low and an amount of 0, `result_o` equals `opnd_i` and `carry_o` equals `carry_i`, whatever the kind code.
- R2: Kind 2'b00 is a left shift that fills with zeros. For an amount n from 1 to 31, `carry_o` is `opnd_i[32-n]`.
- R3: Kind 2'b01 is a right shift that fills with zeros. For an amount n from 1 to 31, `carry_o` is `opnd_i[n-1]`.
- R4: Kind 2'b10 is a right shift that fills the vacated upper bits with copies of `opnd_i[31]`. For an amount n from 1 to 31, `carry_o` is `opnd_i[n-1]`.
- R5: Kind 2'b11 is a right rotation, so bits leaving bit 0 re-enter at bit 31. For an amount n from 1 to 31, `carry_o` is `opnd_i[n-1]`, and the number of set bits does not change.
- R6: When `ext_rot_i` is high, the kind code and the amount have no effect. `result_o` is {`carry_i`, `opnd_i[31:1]`} and `carry_o` is `opnd_i[0]`.
- R7: At the largest amount, 31, every kind follows R2 to R5 exactly, with no wrap of the amount and no loss of the carry bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Source value to be shifted |
| kind_i | input | 2 | Shift kind: 00 left, 01 right zero-fill, 10 right sign-fill, 11 rotate right |
| amt_i | input | 5 | Shift distance, 0 to 31 |
| ext_rot_i | input | 1 | Selects the one-place rotate through carry; overrides kind and amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its default 32-bit width, so the amount port is 5 bits wide and the full range 0 to 31 can be driven. This reaches both boundary amounts: 0, where the carry passes through, and 31, where the carry comes from the opposite end of the word. It also reaches every kind code, with the extended-rotate select both high and low. A behavioural model uses 33-bit arithmetic and a bit-by-bit rotate loop. The bench compares the model with the outputs every clock, first on directed corner cases and then on a long run of random vectors.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } sh_kind_e;

    localparam int SH_KINDS = 4;

endpackage

// File: rtl/opshift_stages.sv
// Logarithmic shift chain for one shift kind; stage s moves by 2**s when amt_i[s] is set.
module opshift_stages #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 5,
    parameter int KIND  = 0
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [WIDTH-1:0] val_o
);

    logic [WIDTH-1:0] st [AMT_W+1];

    assign st[0] = val_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [WIDTH-1:0] moved;

        if (KIND == 0) begin : g_left
            assign moved = st[s] << SH;
        end else if (KIND == 1) begin : g_right_zero
            assign moved = st[s] >> SH;
        end else if (KIND == 2) begin : g_right_sign
            assign moved = $signed(st[s]) >>> SH;
        end else begin : g_rotate
            assign moved = (st[s] >> SH) | (st[s] << (WIDTH - SH));
        end

        assign st[s+1] = amt_i[s] ? moved : st[s];
    end

    assign val_o = st[AMT_W];

endmodule

// File: rtl/opshift_carry.sv
// Picks the last bit shifted out, or passes the incoming carry when nothing leaves the word.
module opshift_carry
    import opshift_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 5
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [AMT_W-1:0] amt_i,
    input  sh_kind_e         kind_i,
    input  logic             ext_i,
    input  logic             carry_i,
    output logic             carry_o
);

    logic [AMT_W-1:0] idx_low;
    logic [AMT_W-1:0] idx_high;

    always_comb begin
        idx_low  = amt_i - AMT_W'(1);
        idx_high = AMT_W'(0) - amt_i;
        if (ext_i) begin
            carry_o = val_i[0];
        end else if (amt_i == '0) begin
            carry_o = carry_i;
        end else begin
            unique case (kind_i)
                SH_LSL:  carry_o = val_i[idx_high];
                SH_LSR,
                SH_ASR,
                SH_ROR:  carry_o = val_i[idx_low];
                default: carry_o = carry_i;
            endcase
        end
    end

endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
    import opshift_pkg::*;
#(
    parameter  int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [1:0]       kind_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             ext_rot_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);

    sh_kind_e         kind;
    logic [WIDTH-1:0] cand [SH_KINDS];
    logic [WIDTH-1:0] ext_val;

    assign kind    = sh_kind_e'(kind_i);
    assign ext_val = {carry_i, opnd_i[WIDTH-1:1]};

    for (genvar k = 0; k < SH_KINDS; k++) begin : g_kind
        opshift_stages #(
            .WIDTH (WIDTH),
            .AMT_W (AMT_W),
            .KIND  (k)
        ) u_stages (
            .val_i (opnd_i),
            .amt_i (amt_i),
            .val_o (cand[k])
        );
    end

    opshift_carry #(
        .WIDTH (WIDTH),
        .AMT_W (AMT_W)
    ) u_carry (
        .val_i   (opnd_i),
        .amt_i   (amt_i),
        .kind_i  (kind),
        .ext_i   (ext_rot_i),
        .carry_i (carry_i),
        .carry_o (carry_o)
    );

    always_comb begin
        if (ext_rot_i) begin
            result_o = ext_val;
        end else begin
            unique case (kind)
                SH_LSL:  result_o = cand[0];
                SH_LSR:  result_o = cand[1];
                SH_ASR:  result_o = cand[2];
                SH_ROR:  result_o = cand[3];
                default: result_o = opnd_i;
            endcase
        end
    end

    // Output checks against the port-level rules
    always_comb begin
        if (!ext_rot_i && amt_i == '0) begin
            assert_zero_pass_R1: assert (result_o == opnd_i && carry_o == carry_i)
                else $error("R1 pass-through broken");
        end
        if (!ext_rot_i && amt_i != '0 && kind == SH_LSL) begin
            assert_left_fill_R2: assert (result_o[0] == 1'b0)
                else $error("R2 left shift did not zero-fill");
        end
        if (!ext_rot_i && amt_i != '0 && kind == SH_LSR) begin
            assert_right_fill_R3: assert (result_o[WIDTH-1] == 1'b0)
                else $error("R3 right shift did not zero-fill");
        end
        if (!ext_rot_i && amt_i != '0 && kind == SH_ASR) begin
            assert_sign_fill_R4: assert (result_o[WIDTH-1] == opnd_i[WIDTH-1])
                else $error("R4 sign not replicated");
        end
        if (!ext_rot_i && kind == SH_ROR) begin
            assert_rot_ones_R5: assert ($countones(result_o) == $countones(opnd_i))
                else $error("R5 rotation changed bit count");
        end
        if (ext_rot_i) begin
            assert_ext_rot_R6: assert (result_o[WIDTH-1] == carry_i && carry_o == opnd_i[0])
                else $error("R6 extended rotate wrong");
        end
    end

endmodule

// File: tb/opshift_unit_test.sv
`timescale 1ns/1ps
module opshift_unit_test;

    localparam int W = 32;
    localparam int MAX_CYCLES = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opnd;
    logic [1:0]   kind;
    logic [4:0]   amt;
    logic         ext;
    logic         cin;
    logic [W-1:0] res;
    logic         cout;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    opshift_unit #(.WIDTH(W)) uut (
        .opnd_i    (opnd),
        .kind_i    (kind),
        .amt_i     (amt),
        .ext_rot_i (ext),
        .carry_i   (cin),
        .result_o  (res),
        .carry_o   (cout)
    );

    // Behavioural reference: returns {carry, value}
    function automatic logic [W:0] model(logic [W-1:0] x, int k, int n, bit e, bit c);
        logic [W:0]        t;
        logic signed [W:0] ts;
        logic [W-1:0]      r;
        logic              cc;
        if (e) return {x[0], c, x[W-1:1]};
        if (n == 0) return {c, x};
        case (k)
            0: begin
                t = {1'b0, x} << n;
                return t;
            end
            1: begin
                t = {x, 1'b0} >> n;
                return {t[0], t[W:1]};
            end
            2: begin
                ts = $signed({x, 1'b0}) >>> n;
                return {ts[0], ts[W:1]};
            end
            default: begin
                r  = x;
                cc = c;
                for (int i = 0; i < n; i++) begin
                    cc = r[0];
                    r  = {r[0], r[W-1:1]};
                end
                return {cc, r};
            end
        endcase
    endfunction

    function automatic string tag_of(int k, int n, bit e);
        if (e) return "R6";
        if (n == 0) return "R1";
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic apply(logic [W-1:0] x, int k, int n, bit e, bit c, string tag);
        logic [W:0] exp_v;
        @(negedge clk);
        opnd = x; kind = 2'(k); amt = 5'(n); ext = e; cin = c;
        #2;
        exp_v = model(x, k, n, e, c);
        checks++;
        if (res !== exp_v[W-1:0] || cout !== exp_v[W]) begin
            failures++;
            $display("FAIL %s: kind=%0d amt=%0d ext=%0b cin=%0b actual=%h/%0b expected=%h/%0b",
                     tag, k, n, e, c, res, cout, exp_v[W-1:0], exp_v[W]);
        end
    endtask

    initial begin
        opnd = '0; kind = '0; amt = '0; ext = 1'b0; cin = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // idle state: all-zero inputs give zero outputs
        apply('0, 0, 0, 0, 0, "R1");
        // R1 amount zero, each kind, both carries
        for (int k = 0; k < 4; k++) begin
            apply(32'hA5C3_0F1E, k, 0, 0, 1, "R1");
            apply(32'h5A3C_F0E1, k, 0, 0, 0, "R1");
        end
        // R2 left shifts
        apply(32'h8000_0001, 0, 1, 0, 0, "R2");
        apply(32'h0000_0003, 0, 31, 0, 0, "R2");
        apply(32'h1234_5678, 0, 4, 0, 1, "R2");
        // R3 right zero-fill
        apply(32'h8000_0001, 1, 1, 0, 0, "R3");
        apply(32'h8000_0000, 1, 31, 0, 1, "R3");
        // R4 sign fill
        apply(32'h8000_0000, 2, 31, 0, 0, "R4");
        apply(32'h7FFF_FFFF, 2, 4, 0, 0, "R4");
        apply(32'hF000_0010, 2, 5, 0, 0, "R4");
        // R5 rotate
        apply(32'h0000_0001, 3, 1, 0, 0, "R5");
        apply(32'h8000_0002, 3, 31, 0, 0, "R5");
        // R6 extended rotate ignores kind and amount
        apply(32'h0000_0002, 1, 17, 1, 1, "R6");
        apply(32'h0000_0003, 0, 31, 1, 0, "R6");
        apply(32'hFFFF_FFFE, 3, 0, 1, 1, "R6");
        // R7 largest amount on every kind
        for (int k = 0; k < 4; k++) begin
            apply(32'h8000_0001, k, 31, 0, 1, "R7");
            apply(32'h4000_0002, k, 31, 0, 0, "R7");
        end
        // random sweep across all modes
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] x;
            int k, n;
            bit e, c;
            x = $urandom;
            k = int'($urandom_range(3, 0));
            n = int'($urandom_range(31, 0));
            e = ($urandom_range(7, 0) == 0);
            c = 1'($urandom);
            apply(x, k, n, e, c, tag_of(k, n, e));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

endmodule